// File: doc/BRIEF.md
# Polynomial-Counter Tone Channel

This block is the waveform core of one audio channel. A 4-bit control code picks one of sixteen waveform modes. A one-cycle advance strobe comes from an external frequency divider, and on each strobe the block steps a 4-bit shift register and a 5-bit shift register. Depending on the mode, those two registers act as one of the following:

- a linear-feedback shift register (LFSR);
- a square-wave divider;
- a three-high, three-low pattern generator;
- a 9-bit LFSR formed by joining the two registers;
- a chain in which the 5-bit stage decides when the 4-bit stage steps.

The channel's one-bit output is the top bit of the 4-bit register. A later stage applies the volume to it and resamples it.

The 5-bit register keeps one extra top bit. That bit holds the bit most recently shifted out of it, which two of the modes forward into the 4-bit register. When a register's working bits are all zero, its LFSR steps load the value 1 instead, so the register recovers from the all-zero state. Reset clears both registers.

Top module: `tone_poly_channel`

## Requirements
In this section, A is the 4-bit register and B is the working low five bits of the 5-bit register. B's extra bit 5 holds the bit last shifted out of it. "A step" is {A[2:0], A[3]^A[2]}, or 1 when A is zero. "A B step" is {B, B[4]^B[2]}, which is six bits, or the value 1 when B is zero.

- R1: When adv_pulse is low, neither register changes, and wave_bit holds its value.
- R2: Reset clears both registers, so wave_bit reads 0 after reset.
- R3: In modes 0x0 and 0xB, every advance shifts a 1 into A[0], so wave_bit is 1 after four advances.
- R4: In mode 0x1, every advance applies an A step. An A that is zero loads 1.
- R5: In modes 0x4 and 0x5, every advance shifts A left and sets the new A[0] to the inverse of the old A[0].
- R6: Every mode that steps B applies a B step, and bit 5 receives the old B[4].
- R7: Modes 0x2, 0x6, 0xA and 0xE apply a B step on every advance. They step A only when the updated B[3:0] equals 4'h8. A is then stepped as follows:
  - mode 0x2: an A step;
  - mode 0x6: the R5 toggle;
  - mode 0xA: a shift that takes in the updated B[4];
  - mode 0xE: the R11 step.
- R8: Modes 0x3, 0x7 and 0xF apply a B step on every advance. They step A only when the updated B[4] is 1, using an A step, the R5 toggle or the R11 step respectively.
- R9: Mode 0x8 works as a 9-bit LFSR. The new B is {B, A[3]^B[4]}, or 1 when both A and B are zero. A then shifts in the new bit 5 of the 5-bit register.
- R10: Mode 0x9 applies a B step and shifts the bit that left B into A[0], unchanged.
- R11: In modes 0xC and 0xD, the next A is ~A shifted left. Its new A[0] is 1 only when the old A[2] is 0 and the old A[2:0] is nonzero. Once the pattern has settled, wave_bit repeats with period 6 and is high for three of every six advances.
- R12: wave_bit equals A[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_pulse | input | 1 | One-cycle advance strobe from the frequency divider |
| ctrl | input | 4 | Waveform mode code |
| wave_bit | output | 1 | Channel output bit |

## Verification
The assertions take for granted that ctrl is stable in the cycle in which adv_pulse is high, and that a gated mode's properties are judged against the mode present on that strobe. No property assumes that the strobes are spaced apart. The stimulus changes ctrl only at the falling clock edge and raises adv_pulse on about half of the cycles, sometimes back to back. Random mode switches leave the registers in states from which each mode must continue. Directed runs start each mode from the cleared state, so the recovery from all-zero registers is exercised.

// File: rtl/tone_poly_channel.sv
module tone_poly_channel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_pulse,
  input  logic [3:0] ctrl,
  output logic       wave_bit
);
  logic [3:0] p4_q, p4_n;
  logic [5:0] p5_q, p5_n, p5_step;
  logic       gate_div, gate_poly;

  function automatic logic [3:0] poly4(input logic [3:0] p);
    return (p != 4'd0) ? {p[2:0], p[3] ^ p[2]} : 4'd1;
  endfunction

  function automatic logic [3:0] half(input logic [3:0] p);
    return {p[2:0], ~p[0]};
  endfunction

  function automatic logic [3:0] six(input logic [3:0] p);
    logic [3:0] inv;
    inv = ~p;
    return {inv[2:0], ~p[2] & (p[2:0] != 3'd0)};
  endfunction

  assign p5_step   = (p5_q[4:0] != 5'd0) ? {p5_q[4:0], p5_q[4] ^ p5_q[2]} : 6'd1;
  assign gate_div  = p5_step[3:0] == 4'h8;
  assign gate_poly = p5_step[4];

  always_comb begin
    p4_n = p4_q;
    p5_n = p5_q;
    case (ctrl)
      4'h0, 4'hB: p4_n = {p4_q[2:0], 1'b1};
      4'h1:       p4_n = poly4(p4_q);
      4'h2: begin
        p5_n = p5_step;
        if (gate_div) p4_n = poly4(p4_q);
      end
      4'h3: begin
        p5_n = p5_step;
        if (gate_poly) p4_n = poly4(p4_q);
      end
      4'h4, 4'h5: p4_n = half(p4_q);
      4'h6: begin
        p5_n = p5_step;
        if (gate_div) p4_n = half(p4_q);
      end
      4'h7: begin
        p5_n = p5_step;
        if (gate_poly) p4_n = half(p4_q);
      end
      4'h8: begin
        p5_n = ((p5_q[4:0] != 5'd0) || (p4_q != 4'd0)) ?
               {p5_q[4:0], p4_q[3] ^ p5_q[4]} : 6'd1;
        p4_n = {p4_q[2:0], p5_n[5]};
      end
      4'h9: begin
        p5_n = p5_step;
        p4_n = {p4_q[2:0], p5_step[5]};
      end
      4'hA: begin
        p5_n = p5_step;
        if (gate_div) p4_n = {p4_q[2:0], p5_step[4]};
      end
      4'hC, 4'hD: p4_n = six(p4_q);
      4'hE: begin
        p5_n = p5_step;
        if (gate_div) p4_n = six(p4_q);
      end
      default: begin
        p5_n = p5_step;
        if (gate_poly) p4_n = six(p4_q);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p4_q <= '0;
      p5_q <= '0;
    end else if (adv_pulse) begin
      p4_q <= p4_n;
      p5_q <= p5_n;
    end
  end

  assign wave_bit = p4_q[3];
endmodule

module tone_poly_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adv_pulse,
  input logic [3:0] ctrl,
  input logic [3:0] p4,
  input logic [5:0] p5,
  input logic       wave_bit
);
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_pulse |=> ($stable(p4) && $stable(p5)));
  // R3
  ones_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_pulse && (ctrl == 4'h0 || ctrl == 4'hB)) |=> (wave_bit == $past(p4[2])));
  // R4
  poly4_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_pulse && ctrl == 4'h1 && p4 == 4'd0) |=> (p4 == 4'd1));
  // R5
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_pulse && (ctrl == 4'h4 || ctrl == 4'h5)) |=> (p4[0] != $past(p4[0])));
  // R7
  div_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_pulse && ctrl == 4'h2) |=> ((p5[3:0] == 4'h8) || (p4 == $past(p4))));
  // R8
  poly_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_pulse && ctrl == 4'h3) |=> (p5[4] || (p4 == $past(p4))));
  // R10
  copy_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_pulse && ctrl == 4'h9) |=> (p4[0] == $past(p5[4])));
endmodule

bind tone_poly_channel tone_poly_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adv_pulse(adv_pulse), .ctrl(ctrl),
  .p4(p4_q), .p5(p5_q), .wave_bit(wave_bit)
);

// File: tb/tone_poly_channel_tb.sv
module tone_poly_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv_pulse = 1'b0;
  logic [3:0] ctrl = 4'h0;
  logic wave_bit;
  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] m4;
  logic [5:0] m5;

  always #2 clk = ~clk;

  tone_poly_channel u_dut (.clk(clk), .rst_n(rst_n), .adv_pulse(adv_pulse),
                           .ctrl(ctrl), .wave_bit(wave_bit));

  function automatic logic [3:0] a_step(input logic [3:0] a);
    if (a == 4'd0) return 4'd1;
    return {a[2:0], a[3] ^ a[2]};
  endfunction

  function automatic logic [5:0] b_step(input logic [5:0] b);
    if (b[4:0] == 5'd0) return 6'd1;
    return {b[4:0], b[4] ^ b[2]};
  endfunction

  function automatic logic [3:0] tog(input logic [3:0] a);
    return {a[2:0], !a[0]};
  endfunction

  function automatic logic [3:0] pat6(input logic [3:0] a);
    logic [3:0] c;
    c = ~a;
    return {c[2:0], (a[2] == 1'b0) && (a[2:0] != 3'd0)};
  endfunction

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'h0, 4'hB: return "R3";
      4'h1: return "R4";
      4'h4, 4'h5: return "R5";
      4'h2, 4'h6, 4'hA, 4'hE: return "R7";
      4'h3, 4'h7, 4'hF: return "R8";
      4'h8: return "R9";
      4'h9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input logic [3:0] c);
    logic [5:0] nb;
    nb = b_step(m5);
    case (c)
      4'h0, 4'hB: m4 = {m4[2:0], 1'b1};
      4'h1: m4 = a_step(m4);
      4'h4, 4'h5: m4 = tog(m4);
      4'h2: begin m5 = nb; if (nb[3:0] == 4'h8) m4 = a_step(m4); end
      4'h6: begin m5 = nb; if (nb[3:0] == 4'h8) m4 = tog(m4); end
      4'hA: begin m5 = nb; if (nb[3:0] == 4'h8) m4 = {m4[2:0], nb[4]}; end
      4'hE: begin m5 = nb; if (nb[3:0] == 4'h8) m4 = pat6(m4); end
      4'h3: begin m5 = nb; if (nb[4]) m4 = a_step(m4); end
      4'h7: begin m5 = nb; if (nb[4]) m4 = tog(m4); end
      4'hF: begin m5 = nb; if (nb[4]) m4 = pat6(m4); end
      4'h8: begin
        if (m5[4:0] == 5'd0 && m4 == 4'd0) m5 = 6'd1;
        else m5 = {m5[4:0], m4[3] ^ m5[4]};
        m4 = {m4[2:0], m5[5]};
      end
      4'h9: begin m5 = nb; m4 = {m4[2:0], nb[5]}; end
      default: m4 = pat6(m4);
    endcase
  endtask

  task automatic check(input string rq, input logic exp);
    n_cmp++;
    if (wave_bit !== exp) begin
      n_bad++;
      $display("FAIL %s: wave_bit=%0b expected=%0b", rq, wave_bit, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] c, input logic a, input string rq);
    ctrl = c;
    adv_pulse = a;
    @(negedge clk);
    adv_pulse = 1'b0;
    if (a) model(c);
    check(rq, m4[3]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m4 = 4'd0;
    m5 = 6'd0;
  endtask

  initial begin
    logic [3:0] c;
    logic w0;
    int ones;
    logic seq [12];
    void'($urandom(32'd2468));
    @(negedge clk);
    do_reset();
    check("R2", 1'b0);

    for (int i = 0; i < 5; i++) cyc(4'h0, 1'b0, "R1");
    for (int i = 0; i < 4; i++) cyc(4'h0, 1'b1, "R3");
    check("R3", 1'b1);

    do_reset();
    for (int i = 0; i < 3; i++) cyc(4'h1, 1'b1, "R4");
    check("R4", 1'b0);
    cyc(4'h1, 1'b1, "R4");
    check("R12", 1'b1);

    do_reset();
    for (int i = 0; i < 12; i++) cyc(4'h9, 1'b1, "R6");

    do_reset();
    for (int i = 0; i < 40; i++) cyc(4'h8, 1'b1, "R9");

    do_reset();
    for (int i = 0; i < 10; i++) cyc(4'h4, 1'b1, "R5");

    do_reset();
    for (int i = 0; i < 12; i++) cyc(4'hC, 1'b1, "R11");
    for (int i = 0; i < 12; i++) begin
      cyc(4'hC, 1'b1, "R11");
      seq[i] = wave_bit;
    end
    ones = 0;
    for (int i = 0; i < 6; i++) begin
      if (seq[i]) ones++;
      n_cmp++;
      if (seq[i] !== seq[i+6]) begin
        n_bad++;
        $display("FAIL R11: period bit %0d=%0b expected=%0b", i, seq[i+6], seq[i]);
      end
    end
    n_cmp++;
    if (ones != 3) begin
      n_bad++;
      $display("FAIL R11: ones per period=%0d expected=3", ones);
    end

    for (int k = 0; k < 16; k++) begin
      do_reset();
      for (int i = 0; i < 70; i++) cyc(4'(k), 1'b1, tag(4'(k)));
    end

    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if ((i % 40) == 0) c = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) cyc(c, 1'b1, tag(c));
      else begin
        w0 = m4[3];
        cyc(4'($urandom_range(0, 15)), 1'b0, "R1");
        if (w0 !== m4[3]) n_bad++;
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule